// File: doc/BRIEF.md
# Motor Stall Protection Timer

This block guards a motor drive against a stalled rotor. While the drive is commanded to run, it watches the speed-lock flag. Every tick that the motor is running but not locked adds one unit of charge to a digital accumulator, which stands in for a timing capacitor. A locked tick neither adds nor removes charge. When the accumulator reaches a programmable 16-bit trip level, the block latches a fault. While that fault is latched, the low-side switches of the bridge are held off.

Stopping the drive clears the fault. Stopping also drains the accumulator by 22 units per tick, with a floor at zero. If the stop is short, some charge remains, and the next trip after a restart comes earlier than the full level would give. A strap input turns protection off completely: it empties the accumulator and clears the fault. An asynchronous power-on reset clears everything.

The controller has four named states:
- **SG_STOP**: stopped.
- **SG_RUN**: running and timing.
- **SG_TRIP**: fault latched.
- **SG_OFF**: protection strapped off.

Transitions take priority in this order:
1. Strap set: any state goes to SG_OFF.
2. Stop requested: any state goes to SG_STOP.
3. From SG_TRIP, stays in SG_TRIP while running.
4. Trip level reached on a tick: goes to SG_TRIP.
5. Otherwise, running: goes to SG_RUN.

Top module: `stall_guard`

## Requirements
- R1: An active-low `rst_n` clears the fault and the accumulator at once, without waiting for a clock. After reset, both outputs are 0.
- R2: While `run`=1, `prot_dis`=0 and no fault is latched, each cycle with `tick`=1 and `locked`=0 adds exactly 1 to the accumulator. The accumulator never wraps.
- R3: A tick with `run`=1 and `locked`=1 leaves the accumulator unchanged.
- R4: `fault` rises at the clock edge of the tick whose increment brings the accumulator to a value >= `trip_level`. From an empty accumulator with back-to-back unlocked ticks, this is the `trip_level`-th tick. With level 0, it is the first tick.
- R5: Once set, `fault` stays set while `run`=1 and `prot_dis`=0, whatever `tick` and `locked` do. The accumulator is frozen while the fault is latched.
- R6: `run`=0 clears `fault` at the next clock edge.
- R7: `lowside_inhibit` is high exactly when `fault`=1, `run`=1 and `prot_dis`=0. It falls in the same cycle that `run` or the strap changes.
- R8: While `run`=0, each tick lowers the accumulator by 22, with a floor at 0.
- R9: After a stop too short to empty the accumulator, the residual charge shortens the next trip. The number of unlocked ticks to trip equals `trip_level` minus the residual.
- R10: `prot_dis`=1 empties the accumulator and clears `fault` at the next edge, and keeps both clear.
- R11: A cycle with `tick`=0 changes neither the accumulator nor the fault (outside reset and strap).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| tick | input | 1 | Time-base enable, one accumulator step per high cycle |
| run | input | 1 | 1 = drive commanded to run, 0 = stop |
| locked | input | 1 | 1 = motor speed inside lock range |
| prot_dis | input | 1 | Strap: 1 = protection disabled |
| trip_level | input | 16 | Accumulator value at which the fault trips |
| lowside_inhibit | output | 1 | Holds low-side switches off |
| fault | output | 1 | Latched stall fault status |

## Verification
The hardest case to reach is a partly drained accumulator. Its value is not visible at the ports, so it can only be inferred from when the next trip comes.

The stimulus charges the accumulator to a known value, with locked ticks and idle cycles mixed in. It then stops the drive for a chosen number of drain ticks and restarts it, and counts the unlocked ticks until `fault` rises. That count must match what follows from the level, the residual and the floor at zero.

A behavioural model in the bench tracks the accumulator as an integer and is compared with both outputs on every clock.

// File: rtl/stall_guard_pkg.sv
package stall_guard_pkg;
    typedef enum logic [1:0] {
        SG_STOP = 2'd0,
        SG_RUN  = 2'd1,
        SG_TRIP = 2'd2,
        SG_OFF  = 2'd3
    } sg_state_t;
endpackage

// File: rtl/stall_accum.sv
module stall_accum #(
    parameter int ACC_W      = 16,
    parameter int DRAIN_STEP = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             locked,
    input  logic             prot_dis,
    input  logic             frozen,
    input  logic [ACC_W-1:0] level,
    output logic [ACC_W-1:0] acc_o,
    output logic             reach_o
);
    localparam logic [ACC_W-1:0] ACC_MAX = {ACC_W{1'b1}};
    localparam logic [ACC_W-1:0] DRAIN_V = ACC_W'(DRAIN_STEP);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_inc;
    logic [ACC_W-1:0] acc_dec;
    logic             charge_en;
    logic             drain_en;

    always_comb begin
        charge_en = run && !prot_dis && !frozen && tick && !locked;
        drain_en  = !run && !prot_dis && tick;
        acc_inc   = (acc_q == ACC_MAX) ? acc_q : acc_q + 1'b1;
        acc_dec   = (acc_q > DRAIN_V) ? acc_q - DRAIN_V : '0;
        reach_o   = charge_en && (acc_inc >= level);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (prot_dis) begin
            acc_q <= '0;
        end else if (drain_en) begin
            acc_q <= acc_dec;
        end else if (charge_en) begin
            acc_q <= acc_inc;
        end
    end

    assign acc_o = acc_q;

    // R8: no charge is ever gained while stopped
    p_no_rise_stopped_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> acc_q <= $past(acc_q));
    // R3: a locked tick in run leaves the charge alone
    p_hold_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && locked && !prot_dis) |=> $stable(acc_q));
    // R2: charge only ever climbs by one unit per cycle
    p_unit_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_q > $past(acc_q)) |-> (acc_q == $past(acc_q) + 1'b1));
    // R11: idle cycles do not move the charge
    p_tick_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !prot_dis) |=> $stable(acc_q));
endmodule

// File: rtl/stall_fsm.sv
module stall_fsm
    import stall_guard_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      run,
    input  logic      prot_dis,
    input  logic      reach,
    output sg_state_t state_o,
    output logic      fault_o,
    output logic      inhibit_o
);
    sg_state_t state_q;
    sg_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SG_STOP;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SG_OFF: begin
                if (!prot_dis) begin
                    if (!run)       state_d = SG_STOP;
                    else if (reach) state_d = SG_TRIP;
                    else            state_d = SG_RUN;
                end
            end
            SG_STOP: begin
                if (prot_dis)   state_d = SG_OFF;
                else if (run)   state_d = reach ? SG_TRIP : SG_RUN;
            end
            SG_RUN: begin
                if (prot_dis)   state_d = SG_OFF;
                else if (!run)  state_d = SG_STOP;
                else if (reach) state_d = SG_TRIP;
            end
            SG_TRIP: begin
                if (prot_dis)   state_d = SG_OFF;
                else if (!run)  state_d = SG_STOP;
            end
            default: state_d = SG_STOP;
        endcase
    end

    always_comb begin
        fault_o   = (state_q == SG_TRIP);
        inhibit_o = fault_o && run && !prot_dis;
    end

    assign state_o = state_q;

    // R5: fault latch holds while running and not strapped off
    p_latch_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o && run && !prot_dis) |=> fault_o);
    // R6: stop releases the fault
    p_stop_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !fault_o);
    // R7: inhibit only with a latched fault and run
    p_inhibit_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit_o |-> (fault_o && run));
    // R4: a new fault needs the threshold crossing one edge earlier
    p_trip_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_o) |-> $past(reach));
    // R10: strap clears the fault
    p_strap_fault_r10: assert property (@(posedge clk) disable iff (!rst_n)
        prot_dis |=> !fault_o);
endmodule

// File: rtl/stall_guard.sv
module stall_guard
    import stall_guard_pkg::*;
#(
    parameter int ACC_W      = 16,
    parameter int DRAIN_STEP = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             locked,
    input  logic             prot_dis,
    input  logic [ACC_W-1:0] trip_level,
    output logic             lowside_inhibit,
    output logic             fault
);
    sg_state_t        state;
    logic [ACC_W-1:0] acc;
    logic             reach;
    logic             frozen;

    assign frozen = (state == SG_TRIP);

    stall_accum #(
        .ACC_W      (ACC_W),
        .DRAIN_STEP (DRAIN_STEP)
    ) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .run      (run),
        .locked   (locked),
        .prot_dis (prot_dis),
        .frozen   (frozen),
        .level    (trip_level),
        .acc_o    (acc),
        .reach_o  (reach)
    );

    stall_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .prot_dis  (prot_dis),
        .reach     (reach),
        .state_o   (state),
        .fault_o   (fault),
        .inhibit_o (lowside_inhibit)
    );

    // R10: strap empties the accumulator
    p_strap_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        prot_dis |=> (acc == '0));
    // R5: charge is frozen while the fault is latched in run
    p_frozen_acc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && run && !prot_dis) |=> $stable(acc));
endmodule

// File: tb/tb_stall_guard.sv
`timescale 1ns/1ps
module tb_stall_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        run = 1'b0;
    logic        locked = 1'b0;
    logic        prot_dis = 1'b0;
    logic [15:0] trip_level = 16'd10;
    logic        lowside_inhibit;
    logic        fault;

    int    checks = 0;
    int    errors = 0;
    int    m_acc = 0;
    bit    m_fault = 1'b0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    stall_guard dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .locked(locked),
        .prot_dis(prot_dis), .trip_level(trip_level),
        .lowside_inhibit(lowside_inhibit), .fault(fault)
    );

    task automatic check(input string req, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // behavioural reference, applied at each rising edge
    task automatic model_edge();
        if (!rst_n) begin
            m_acc = 0; m_fault = 1'b0;
        end else if (prot_dis) begin
            m_acc = 0; m_fault = 1'b0;
        end else if (!run) begin
            m_fault = 1'b0;
            if (tick) m_acc = (m_acc > 22) ? m_acc - 22 : 0;
        end else if (!m_fault && tick && !locked) begin
            if (m_acc < 65535) m_acc = m_acc + 1;
            if (m_acc >= int'(trip_level)) m_fault = 1'b1;
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(cur_req, fault, m_fault, "fault");
        check(cur_req, lowside_inhibit, m_fault && run && !prot_dis, "lowside_inhibit");
    endtask

    task automatic drive(input logic r, input logic t, input logic l);
        run = r; tick = t; locked = l;
    endtask

    task automatic ticks_to_trip(input int limit, output int n);
        n = 0;
        drive(1'b1, 1'b1, 1'b0);
        while (!fault && n < limit) begin
            step();
            n++;
        end
    endtask

    initial begin
        #(5.0 * 190000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        // R1: reset state
        cur_req = "R1";
        #12;
        check("R1", fault, 1'b0, "fault in reset");
        check("R1", lowside_inhibit, 1'b0, "inhibit in reset");
        @(negedge clk); rst_n = 1'b1;
        step();

        // R4 / R2: trip on the tenth unlocked tick from empty
        cur_req = "R4"; trip_level = 16'd10;
        ticks_to_trip(100, n);
        check_int("R4", n, 10, "ticks to trip level 10");
        check("R7", lowside_inhibit, 1'b1, "inhibit while faulted");

        // R5: fault holds through locked ticks and idle cycles
        cur_req = "R5";
        for (int i = 0; i < 6; i++) begin
            drive(1'b1, i[0], i[1]);
            step();
        end
        check("R5", fault, 1'b1, "fault held");

        // R6 / R7: stop drops inhibit at once, fault next edge
        cur_req = "R6";
        drive(1'b0, 1'b0, 1'b0);
        #0.5;
        check("R7", lowside_inhibit, 1'b0, "inhibit drops with run");
        step();
        check("R6", fault, 1'b0, "fault cleared by stop");
        drive(1'b0, 1'b1, 1'b0);
        step();  // 10 -> 0

        // R3 / R11 / R2: charge 50 with locked and idle cycles mixed in
        cur_req = "R3"; trip_level = 16'd60;
        for (int i = 0; i < 80; i++) begin
            if (i % 4 == 1)      drive(1'b1, 1'b1, 1'b1);  // R3 locked tick
            else if (i % 4 == 3) drive(1'b1, 1'b0, 1'b0);  // R11 idle cycle
            else                 drive(1'b1, 1'b1, 1'b0);  // R2 charge
            step();
        end
        check("R2", fault, 1'b0, "no trip at 40 units");
        cur_req = "R2";
        for (int i = 0; i < 10; i++) begin
            drive(1'b1, 1'b1, 1'b0); step();
        end
        check("R3", fault, 1'b0, "locked and idle cycles added nothing");

        // R8 / R9: one drain tick leaves 28, stopped idle cycles keep it
        cur_req = "R8";
        drive(1'b0, 1'b1, 1'b0); step();
        for (int i = 0; i < 5; i++) begin
            drive(1'b0, 1'b0, 1'b0); step();
        end
        cur_req = "R9";
        ticks_to_trip(200, n);
        check_int("R9", n, 32, "early trip after short stop");

        // R8: two drain ticks from 60 leave 16
        cur_req = "R8";
        drive(1'b0, 1'b1, 1'b0); step(); step();
        ticks_to_trip(200, n);
        check_int("R8", n, 44, "trip after two drain ticks");

        // R8: long stop floors at zero, full level again
        drive(1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 5; i++) step();
        ticks_to_trip(200, n);
        check_int("R8", n, 60, "full trip after complete drain");

        // R4: level zero trips on the first tick
        cur_req = "R4";
        drive(1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 4; i++) step();
        trip_level = 16'd0;
        ticks_to_trip(20, n);
        check_int("R4", n, 1, "level zero trip");

        // R10: strap clears fault and empties charge
        cur_req = "R10";
        prot_dis = 1'b1;
        #0.5;
        check("R7", lowside_inhibit, 1'b0, "inhibit drops with strap");
        step();
        check("R10", fault, 1'b0, "strap clears fault");
        trip_level = 16'd5;
        for (int i = 0; i < 30; i++) begin
            drive(1'b1, 1'b1, 1'b0); step();
        end
        check("R10", fault, 1'b0, "no trip while strapped");
        prot_dis = 1'b0;
        trip_level = 16'd25;
        ticks_to_trip(100, n);
        check_int("R10", n, 25, "strap left accumulator empty");

        // R4: lowering level below current charge trips on next tick
        cur_req = "R4";
        drive(1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 3; i++) step();
        trip_level = 16'd40;
        drive(1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 30; i++) step();
        trip_level = 16'd12;
        ticks_to_trip(10, n);
        check_int("R4", n, 1, "trip after level lowered");

        // R1: asynchronous reset mid-fault
        cur_req = "R1";
        #1 rst_n = 1'b0;
        m_acc = 0; m_fault = 1'b0;
        #0.5;
        check("R1", fault, 1'b0, "async reset clears fault");
        check("R1", lowside_inhibit, 1'b0, "async reset clears inhibit");
        @(negedge clk); rst_n = 1'b1;
        trip_level = 16'd7;
        ticks_to_trip(50, n);
        check_int("R1", n, 7, "reset emptied accumulator");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule